// File: doc/BRIEF.md
# I2C Target with 256-Byte Word-Addressed Memory

This block is an I2C target that serves a 256-byte on-chip memory. It watches the serial clock and data lines through synchronisers running on a system clock at least sixteen times faster than the bus. It recognises START, repeated START and STOP conditions, and it answers only to its own 7-bit device address. A write transfer carries a one-byte word address, which may be followed by up to sixteen data bytes for the same 16-byte page. A read transfer returns bytes from an internal pointer. The pointer can be set first with a dummy write, and it keeps advancing while the host acknowledges.

Written bytes are first collected in a page buffer. They reach the memory only when a STOP closes the transfer. A timed internal write cycle follows, and for its whole length the target does not answer its own address, so a host can poll until the target acknowledges again. A write-protect level refuses data bytes. A hold level forces the target off the bus, drops any partly received page and blocks new transfers, but it does not stop a write cycle that is already running. The data output is an open-drain pull-down enable.

Top module: `i2c_byte_mem`

## Requirements
- R1: The first byte after a START carries the device address in bits 7..1 (default 7'b1010000) and the direction in bit 0 (1 = read, 0 = write). The target pulls SDA low in the ninth clock only when the address matches, and it ignores all later bytes until the next START.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START restarts address reception. The target changes its SDA drive only while SCL is low.
- R3: In a write transfer, the byte after the device address is acknowledged and loads the 8-bit word pointer.
- R4: Every later data byte is acknowledged and buffered at the page base (pointer bits 7..4) plus an offset (bits 3..0). The offset increments modulo 16, so a 17th byte overwrites the first. Only offsets actually received change in memory, and only when a STOP arrives.
- R5: A STOP that follows buffered data starts a write cycle of WCYC_CYCLES system clocks. During that cycle the device address gets no acknowledge. After it, the address is acknowledged again.
- R6: While write-protect is high, the device address and word address are acknowledged, but a data byte is not, and memory is unchanged.
- R7: A read that starts without setting the pointer returns the byte at the last accessed address plus one, wrapping from 255 to 0.
- R8: A random read (word address write, repeated START, read address) returns the byte at that word address.
- R9: Each host acknowledge during a read makes the target send the next byte, with all 8 pointer bits incrementing and wrapping from 255 to 0. A host NACK makes the target release SDA until the next START or STOP.
- R10: While hold is high, the target releases SDA, abandons the current transfer together with its buffered bytes, and acknowledges nothing. A write cycle already running still completes.
- R11: A STOP after only the word address starts no write cycle, and the pointer keeps that word address.
- R12: After reset SDA is released, the pointer is 0 and every memory byte reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| wp_i | input | 1 | Write-protect level, 1 refuses data bytes |
| hold_i | input | 1 | 1 = target held off the bus |

## Verification
On every cycle, the assertions check four things: the data drive moves only while the synchronised clock is low, the drive is released one cycle after hold, no address is acknowledged while a write cycle runs, and no commit starts while one is running. They also check that the page base stays fixed while data bytes stream in. Some behaviour only the bench's bus scenarios can show. This covers the address sweep over all 128 device addresses, page wrap and partial-page commits, write-protect refusal, pointer wrap in current and sequential reads, and hold during a transfer or during a write cycle. A final dump of all 256 bytes is compared against the bench's own model.

// File: rtl/i2cm_pkg.sv
// Shared types for the I2C byte-memory target.
// Assumes: a single protocol engine uses these states.
package i2cm_pkg;
    typedef enum logic [3:0] {
        S_IDLE,     // waiting for a START
        S_DEV,      // shifting in the device address byte
        S_ACK_DEV,  // acknowledging the device address
        S_WADDR,    // shifting in the word address
        S_ACK_WA,   // acknowledging the word address
        S_WDATA,    // shifting in a data byte
        S_ACK_WD,   // acknowledging a data byte
        S_TX,       // sending a read byte
        S_RACK,     // sampling the host acknowledge
        S_WAIT      // released, waiting for START or STOP
    } bus_st_e;
endpackage

// File: rtl/i2cm_sync.sv
// Two-flop synchroniser bank with a one-cycle history register per line.
// Assumes: inputs idle high (bus lines); reset loads the idle level.
module i2cm_sync #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] prv_o
);
    logic [LINES-1:0] meta_q;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Purpose: resynchronise one line and keep its previous sample.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b1;
                lvl_o[g]  <= 1'b1;
                prv_o[g]  <= 1'b1;
            end else begin
                meta_q[g] <= raw_i[g];
                lvl_o[g]  <= meta_q[g];
                prv_o[g]  <= lvl_o[g];
            end
        end
    end
endmodule

// File: rtl/i2cm_store.sv
// Memory array, page buffer and timed write-cycle counter.
// Assumes: commit and buffer clear never coincide; the read port is combinational.
module i2cm_store #(
    parameter int DEPTH       = 256,
    parameter int PAGE        = 16,
    parameter int WCYC_CYCLES = 250000,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(PAGE),
    localparam int HW = AW - PW,
    localparam int TW = $clog2(WCYC_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_wr_i,
    input  logic [PW-1:0] buf_idx_i,
    input  logic [7:0]    buf_dat_i,
    input  logic          buf_clr_i,
    input  logic          commit_i,
    input  logic [HW-1:0] commit_page_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o,
    output logic          busy_o,
    output logic          buf_any_o
);
    logic [7:0]      mem_q [DEPTH];
    logic [7:0]      pbuf_q [PAGE];
    logic [PAGE-1:0] vld_q;
    logic [TW-1:0]   wcnt_q;

    assign rd_data_o = mem_q[rd_addr_i];
    assign busy_o    = (wcnt_q != '0);
    assign buf_any_o = |vld_q;

    // Purpose: hold the page buffer contents and their valid flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < PAGE; i++) pbuf_q[i] <= '0;
        end else if (commit_i || buf_clr_i) begin
            vld_q <= '0;
        end else if (buf_wr_i) begin
            pbuf_q[buf_idx_i] <= buf_dat_i;
            vld_q[buf_idx_i]  <= 1'b1;
        end
    end

    // Purpose: copy every valid buffered byte into its page on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (commit_i) begin
            for (int i = 0; i < PAGE; i++) begin
                if (vld_q[i]) mem_q[{commit_page_i, PW'(i)}] <= pbuf_q[i];
            end
        end
    end

    // Purpose: time the internal write cycle; runs regardless of hold.
    always_ff @(posedge clk) begin
        if (!rst_n)               wcnt_q <= '0;
        else if (commit_i)        wcnt_q <= TW'(WCYC_CYCLES);
        else if (wcnt_q != '0)    wcnt_q <= wcnt_q - 1'b1;
    end

    // R5: a new commit never lands inside a running write cycle
    assert_commit_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> !busy_o);
endmodule

// File: rtl/i2cm_fsm.sv
// Bus protocol engine: condition detection, address match, byte shifting,
// acknowledge generation and pointer handling.
// Assumes: synchronised SCL/SDA levels with one-cycle history; clock >= 16x bus.
module i2cm_fsm
    import i2cm_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1010000,
    parameter int DEPTH = 256,
    parameter int PAGE  = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(PAGE),
    localparam int HW = AW - PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s_i,
    input  logic          scl_p_i,
    input  logic          sda_s_i,
    input  logic          sda_p_i,
    input  logic          wp_i,
    input  logic          hold_i,
    input  logic          busy_i,
    input  logic          buf_any_i,
    input  logic [7:0]    rd_data_i,
    output logic          buf_wr_o,
    output logic [PW-1:0] buf_idx_o,
    output logic [7:0]    buf_dat_o,
    output logic          buf_clr_o,
    output logic          commit_o,
    output logic [HW-1:0] commit_page_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          sda_oe_o
);
    localparam logic [3:0]    BYTE_DONE = 4'd8;
    localparam logic [PW-1:0] ONE_P     = PW'(1);
    localparam logic [AW-1:0] ONE_A     = AW'(1);

    bus_st_e       st_q;
    logic [3:0]    cnt_q;
    logic [7:0]    sh_q;
    logic [AW-1:0] ptr_q;
    logic          oe_q;
    logic          mack_q;

    logic scl_rise, scl_fall, start_det, stop_det, byte_in, rx_state;

    assign scl_rise  = scl_s_i & ~scl_p_i;
    assign scl_fall  = ~scl_s_i & scl_p_i;
    assign start_det = scl_s_i & scl_p_i & sda_p_i & ~sda_s_i;
    assign stop_det  = scl_s_i & scl_p_i & ~sda_p_i & sda_s_i;
    assign rx_state  = (st_q == S_DEV) || (st_q == S_WADDR) || (st_q == S_WDATA);
    assign byte_in   = scl_fall && (cnt_q == BYTE_DONE);

    assign buf_wr_o      = !hold_i && !stop_det && !start_det && (st_q == S_WDATA)
                           && byte_in && !wp_i;
    assign buf_idx_o     = ptr_q[PW-1:0];
    assign buf_dat_o     = sh_q;
    assign buf_clr_o     = hold_i || start_det;
    assign commit_o      = !hold_i && stop_det && buf_any_i;
    assign commit_page_o = ptr_q[AW-1:PW];
    assign rd_addr_o     = ptr_q;
    assign sda_oe_o      = oe_q;

    // Purpose: advance the protocol state, shift bits and drive acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            cnt_q  <= '0;
            sh_q   <= '0;
            ptr_q  <= '0;
            oe_q   <= 1'b0;
            mack_q <= 1'b0;
        end else if (hold_i) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            oe_q  <= 1'b0;
        end else if (stop_det) begin
            st_q <= S_IDLE;
            oe_q <= 1'b0;
        end else if (start_det) begin
            st_q  <= S_DEV;
            cnt_q <= '0;
            oe_q  <= 1'b0;
        end else if (rx_state && scl_rise && cnt_q != BYTE_DONE) begin
            sh_q  <= {sh_q[6:0], sda_s_i};
            cnt_q <= cnt_q + 1'b1;
        end else begin
            case (st_q)
                S_DEV: if (byte_in) begin
                    if (sh_q[7:1] == DEV_ADDR && !busy_i) begin
                        oe_q <= 1'b1;
                        st_q <= S_ACK_DEV;
                    end else begin
                        st_q <= S_IDLE;
                    end
                end
                S_ACK_DEV: if (scl_fall) begin
                    cnt_q <= '0;
                    if (sh_q[0]) begin
                        sh_q <= rd_data_i;
                        oe_q <= ~rd_data_i[7];
                        st_q <= S_TX;
                    end else begin
                        oe_q <= 1'b0;
                        st_q <= S_WADDR;
                    end
                end
                S_WADDR: if (byte_in) begin
                    ptr_q <= sh_q;
                    oe_q  <= 1'b1;
                    st_q  <= S_ACK_WA;
                end
                S_ACK_WA, S_ACK_WD: if (scl_fall) begin
                    oe_q  <= 1'b0;
                    cnt_q <= '0;
                    st_q  <= S_WDATA;
                end
                S_WDATA: if (byte_in) begin
                    if (wp_i) begin
                        st_q <= S_WAIT;
                    end else begin
                        ptr_q[PW-1:0] <= ptr_q[PW-1:0] + ONE_P;
                        oe_q <= 1'b1;
                        st_q <= S_ACK_WD;
                    end
                end
                S_TX: if (scl_fall) begin
                    if (cnt_q == 4'd7) begin
                        oe_q  <= 1'b0;
                        ptr_q <= ptr_q + ONE_A;
                        st_q  <= S_RACK;
                    end else begin
                        sh_q  <= {sh_q[6:0], 1'b0};
                        oe_q  <= ~sh_q[6];
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_RACK: begin
                    if (scl_rise) mack_q <= ~sda_s_i;
                    if (scl_fall) begin
                        cnt_q <= '0;
                        if (mack_q) begin
                            sh_q <= rd_data_i;
                            oe_q <= ~rd_data_i[7];
                            st_q <= S_TX;
                        end else begin
                            st_q <= S_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R5: the address acknowledge is only entered when no write cycle runs
    assert_no_ack_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_ACK_DEV && $past(st_q) != S_ACK_DEV) |-> !$past(busy_i));

    // R10: hold releases the data line on the next cycle
    assert_hold_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !sda_oe_o);

    // R4: the page base stays fixed while data bytes stream in
    assert_page_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == S_WDATA || st_q == S_ACK_WD) &&
         ($past(st_q) == S_WDATA || $past(st_q) == S_ACK_WD))
        |-> $stable(ptr_q[AW-1:PW]));
endmodule

// File: rtl/i2c_byte_mem.sv
// Top: I2C target with a 256-byte word-addressed memory and page writes.
// Assumes: clk runs at least 16x the bus bit rate; sda_oe_o drives an open-drain pad.
module i2c_byte_mem #(
    parameter logic [6:0] DEV_ADDR    = 7'b1010000,
    parameter int         DEPTH       = 256,
    parameter int         PAGE        = 16,
    parameter int         WCYC_CYCLES = 250000,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(PAGE),
    localparam int HW = AW - PW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    input  logic wp_i,
    input  logic hold_i
);
    logic [1:0]    lvl, prv;
    logic          buf_wr, buf_clr, commit, busy, buf_any;
    logic [PW-1:0] buf_idx;
    logic [7:0]    buf_dat, rd_data;
    logic [HW-1:0] commit_page;
    logic [AW-1:0] rd_addr;

    i2cm_sync #(.LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}),
        .lvl_o(lvl), .prv_o(prv)
    );

    i2cm_fsm #(.DEV_ADDR(DEV_ADDR), .DEPTH(DEPTH), .PAGE(PAGE)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_s_i(lvl[1]), .scl_p_i(prv[1]), .sda_s_i(lvl[0]), .sda_p_i(prv[0]),
        .wp_i(wp_i), .hold_i(hold_i), .busy_i(busy), .buf_any_i(buf_any),
        .rd_data_i(rd_data), .buf_wr_o(buf_wr), .buf_idx_o(buf_idx),
        .buf_dat_o(buf_dat), .buf_clr_o(buf_clr), .commit_o(commit),
        .commit_page_o(commit_page), .rd_addr_o(rd_addr), .sda_oe_o(sda_oe_o)
    );

    i2cm_store #(.DEPTH(DEPTH), .PAGE(PAGE), .WCYC_CYCLES(WCYC_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .buf_wr_i(buf_wr), .buf_idx_i(buf_idx),
        .buf_dat_i(buf_dat), .buf_clr_i(buf_clr), .commit_i(commit),
        .commit_page_i(commit_page), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .busy_o(busy), .buf_any_o(buf_any)
    );

    // R2: the data drive only moves while the synchronised clock is low
    assert_oe_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[1] && prv[1] && !hold_i && !$past(hold_i)) |-> $stable(sda_oe_o));
endmodule

// File: tb/i2c_byte_mem_tb_top.sv
module i2c_byte_mem_tb_top;
    localparam int WC = 600;
    localparam int Q  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0, hold = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   total = 0, bad = 0;
    logic done = 1'b0;
    logic [7:0] mdl [256];

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_byte_mem #(.WCYC_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .wp_i(wp), .hold_i(hold)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bstart();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic wbit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line;
        tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(~give_ack);
    endtask

    // Write n bytes from word address a; data = seed + 3*i
    task automatic page_write(input logic [7:0] a, input int n, input int seed);
        logic ack;
        logic [7:0] d;
        bstart();
        wbyte(8'hA0, ack); chk("R1 write address ack", ack, 1);
        wbyte(a, ack);     chk("R3 word address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            d = 8'(seed + 3 * i);
            wbyte(d, ack); chk("R4 data byte ack", ack, 1);
            mdl[{a[7:4], 4'(a[3:0] + i)}] = d;
        end
        bstop();
    endtask

    task automatic poll(output logic ack);
        bstart(); wbyte(8'hA0, ack); bstop();
    endtask

    task automatic wait_ready();
        logic ack = 1'b0;
        for (int i = 0; i < 20 && !ack; i++) poll(ack);
        chk("R5 ready after write cycle", ack, 1);
    endtask

    // Random read setup (R8, R2 repeated start) then n sequential bytes (R9)
    task automatic read_seq(input logic [7:0] a, input int n);
        logic ack;
        logic [7:0] d;
        bstart();
        wbyte(8'hA0, ack); chk("R8 dummy write ack", ack, 1);
        wbyte(a, ack);     chk("R8 word address ack", ack, 1);
        bstart();
        wbyte(8'hA1, ack); chk("R2 repeated start read ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(i != n - 1, d);
            chk(i == 0 ? "R8 random read data" : "R9 sequential data",
                d, mdl[8'(a + i)]);
        end
        tick(Q);
        chk("R9 released after host nack", sda_oe, 0);
        bstop();
    endtask

    task automatic cur_read(input string tag, input int exp);
        logic ack;
        logic [7:0] d;
        bstart();
        wbyte(8'hA1, ack); chk("R7 current read ack", ack, 1);
        rbyte(1'b0, d);    chk(tag, d, exp);
        bstop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        chk("R12 sda released after reset", sda_oe, 0);
        cur_read("R12 pointer 0 reads zero", 0);

        // R1: sweep every device address with write direction
        for (int a = 0; a < 128; a++) begin
            bstart();
            wbyte({7'(a), 1'b0}, ack);
            chk("R1 address match ack", ack, (a == 7'h50) ? 1 : 0);
            if (a != 7'h50) begin
                wbyte(8'h00, ack);
                chk("R1 later bytes ignored", ack, 0);
            end
            bstop();
        end

        // R4/R5: full page, busy window, then readback
        page_write(8'h20, 16, 8'h11);
        poll(ack); chk("R5 nack during write cycle", ack, 0);
        tick(WC);
        poll(ack); chk("R5 ack after write cycle", ack, 1);
        read_seq(8'h20, 16);

        // R4: 18 bytes from offset E wrap inside the page
        page_write(8'h3E, 18, 8'h40);
        wait_ready();
        read_seq(8'h30, 16);

        // R4: partial page commits only received offsets
        page_write(8'h45, 3, 8'h90);
        wait_ready();
        read_seq(8'h44, 5);

        // R6: write protect refuses data byte
        wp = 1'b1;
        bstart();
        wbyte(8'hA0, ack); chk("R6 address ack with protect", ack, 1);
        wbyte(8'h60, ack); chk("R6 word address ack with protect", ack, 1);
        wbyte(8'h5A, ack); chk("R6 data byte refused", ack, 0);
        bstop();
        wp = 1'b0;
        poll(ack); chk("R6 no write cycle after refusal", ack, 1);
        read_seq(8'h60, 1);

        // R11: stop after word address only
        bstart();
        wbyte(8'hA0, ack); wbyte(8'h21, ack);
        bstop();
        cur_read("R11 pointer kept, no write cycle", mdl[8'h21]);

        // R7/R9: wrap at the top of memory
        page_write(8'hF0, 16, 8'h07);
        wait_ready();
        read_seq(8'hFF, 1);
        cur_read("R7 current read wraps to 0", mdl[8'h00]);
        read_seq(8'hFE, 4);

        // R10: hold during a transfer drops buffered bytes
        bstart();
        wbyte(8'hA0, ack); wbyte(8'h80, ack);
        wbyte(8'h11, ack); chk("R10 data ack before hold", ack, 1);
        hold = 1'b1;
        wbyte(8'h22, ack); chk("R10 no ack while held", ack, 0);
        bstop();
        bstart();
        wbyte(8'hA0, ack); chk("R10 no new transfer while held", ack, 0);
        bstop();
        hold = 1'b0;
        poll(ack); chk("R10 dropped page starts no write cycle", ack, 1);
        read_seq(8'h80, 2);

        // R10: hold does not abort a running write cycle
        page_write(8'h90, 4, 8'hC3);
        hold = 1'b1;
        tick(WC + 50);
        hold = 1'b0;
        poll(ack); chk("R10 write cycle finished under hold", ack, 1);

        // R9/R12: full dump against the model
        read_seq(8'h00, 256);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule